// File: doc/BRIEF.md
# Programmable Power-of-Two Timer

This block divides its clock by a selectable power of two. A 16-bit binary counter advances on every rising clock edge. A two-bit select picks one of four counter bits as the timing source. In recycle mode the selected bit is sent to the output without pause, so the block works as a continuous square-wave divider. In single-cycle mode the output makes one transition when the selected bit first rises, halfway through the selected period. It then holds that level until the block is cleared again.

Two requests clear the block: an external master reset, and a power-on request that its own disable input can mask. Both are synchronised to the clock and act synchronously. While either one is in effect, the counter holds at zero and the output shows the polarity-select level. A change on the mode input also clears the counter and the one-shot latch, in the same way a reset does, but does not force the output level. A polarity input inverts the output in every state.

Top module: `pow2_timer`

## Requirements
- R1: While a clear request is in effect, the output equals `pol_i` (0 gives low, 1 gives high), and it stays there however long the request is held.
- R2: The counter does not advance while a clear request is in effect. Each request passes through two synchroniser flops, so the first count happens on the third rising edge after the request is released.
- R3: The tap select chooses the counter stage as follows: `tap_sel_i` = 2'b00 gives stage 13, 2'b01 gives stage 10, 2'b10 gives stage 8, and 2'b11 gives stage 16. Stage k is counter bit k-1. After release, the first output transition comes 2 + 2^(k-1) rising edges later.
- R4: With `mode_i` = 1 (recycle), the output equals the selected counter bit XOR `pol_i`. Its transitions repeat every 2^(k-1) edges, giving a period of 2^k clocks.
- R5: With `mode_i` = 0 (single cycle), the output makes exactly one transition, when the selected bit first becomes 1. It then holds the level NOT `pol_i` for any further number of counts.
- R6: A change of `mode_i`, in either direction, clears the counter and the one-shot latch on the next rising edge. The next transition follows 2^(k-1) edges after that clearing edge.
- R7: `por_req_i` acts as a clear request when `por_dis_i` = 0.
- R8: When `por_dis_i` = 1, `por_req_i` has no effect, and counting continues undisturbed.
- R9: Changing `tap_sel_i` while counting changes the output in the same cycle, from the counter's current value, without clearing the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock, rising edge |
| mreset_i | input | 1 | Master clear, active high |
| por_req_i | input | 1 | Power-on clear request, active high |
| por_dis_i | input | 1 | 1 masks the power-on request |
| tap_sel_i | input | 2 | Counter stage select |
| mode_i | input | 1 | 1 selects recycle, 0 selects single cycle |
| pol_i | input | 1 | Output polarity and level while cleared |
| timer_o | output | 1 | Timer output |

## Verification
A mode flip and the selected bit reaching its half-period value can fall on the same edge. In that case the clear must win, and the output must not show a transition. The bench provokes a nearby case. It fires the one-shot, flips the mode on the next falling edge, and then requires the output to be back at the polarity level one edge later, with the following transition a full 2^(k-1) edges after the clearing edge. It then flips the mode back while the selected bit is high, and checks that the latch restarts from a cleared state rather than keeping its earlier firing.

// File: rtl/pow2_timer_pkg.sv
package pow2_timer_pkg;

  localparam int CNT_W   = 16;
  localparam int SYNC_N  = 2;

  typedef logic [1:0] tap_sel_t;
  typedef enum logic { MODE_ONESHOT = 1'b0, MODE_RECYCLE = 1'b1 } tmode_e;

  // Counter stage number (1-based) selected by the two-bit select.
  function automatic int tap_stage(input tap_sel_t sel);
    case (sel)
      2'b00:   return 13;
      2'b01:   return 10;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

  // Number of counts until the selected stage first rises.
  function automatic int unsigned half_period(input tap_sel_t sel);
    return 32'd1 << (tap_stage(sel) - 1);
  endfunction

  // Output level as a function of state; shared meaning for all modes.
  function automatic logic out_level(input logic cleared, input logic pol,
                                     input tmode_e mode, input logic tap,
                                     input logic latched);
    if (cleared) return pol;
    if (mode == MODE_RECYCLE) return pol ^ tap;
    return pol ^ (tap | latched);
  endfunction

endpackage

// File: rtl/pow2_clear_sync.sv
module pow2_clear_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic mreset_i,
  input  logic por_req_i,
  input  logic por_dis_i,
  output logic clear_o
);
  logic              req_raw;
  logic [STAGES-1:0] chain_q = '0;

  assign req_raw = mreset_i | (por_req_i & ~por_dis_i);

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i) chain_q[0] <= req_raw;
      end else begin : g_next
        always_ff @(posedge clk_i) chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign clear_o = chain_q[STAGES-1];
endmodule

// File: rtl/pow2_counter.sv
module pow2_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q = '0;
  logic             clr_q = 1'b0;

  always_ff @(posedge clk_i) begin
    clr_q <= clr_i;
    if (clr_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2: a clearing edge leaves the counter at zero
  always_comb begin
    if (clr_q) p_clear_zero_r2: assert (cnt_q == '0);
  end

  // R2: without a clear, each edge adds exactly one
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (clr_i)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pow2_tap_mux.sv
module pow2_tap_mux
  import pow2_timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  tap_sel_t         sel_i,
  output logic             tap_o
);
  logic [WIDTH-1:0] onehot;

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign onehot[b] = (tap_stage(sel_i) == b + 1);
    end
  endgenerate

  assign tap_o = |(onehot & cnt_i);

  // R3: exactly one stage is selected for every select value
  always_comb begin
    p_one_tap_r3: assert ($countones(onehot) == 1);
  end
endmodule

// File: rtl/pow2_oneshot.sv
module pow2_oneshot (
  input  logic clk_i,
  input  logic clr_i,
  input  logic tap_i,
  output logic latched_o
);
  logic latch_q = 1'b0;

  always_ff @(posedge clk_i) begin
    if (clr_i)      latch_q <= 1'b0;
    else if (tap_i) latch_q <= 1'b1;
  end

  assign latched_o = latch_q;

  // R5: once set, only a clear releases the latch
  p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (clr_i)
    latch_q |=> latch_q);

  // R5: the latch sets at the edge after the tap is seen high
  p_latch_set_r5: assert property (@(posedge clk_i) disable iff (clr_i)
    tap_i |=> latch_q);
endmodule

// File: rtl/pow2_timer.sv
module pow2_timer
  import pow2_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       mreset_i,
  input  logic       por_req_i,
  input  logic       por_dis_i,
  input  logic [1:0] tap_sel_i,
  input  logic       mode_i,
  input  logic       pol_i,
  output logic       timer_o
);
  localparam int W = CNT_W;

  logic         rst_active;
  logic         mode_q = 1'b0;
  logic         mode_change;
  logic         clr_cnt;
  logic [W-1:0] count;
  logic         tap_bit;
  logic         latched;
  logic         mode_change_q = 1'b0;

  pow2_clear_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i     (clk_i),
    .mreset_i  (mreset_i),
    .por_req_i (por_req_i),
    .por_dis_i (por_dis_i),
    .clear_o   (rst_active)
  );

  always_ff @(posedge clk_i) begin
    mode_q        <= mode_i;
    mode_change_q <= mode_change;
  end

  assign mode_change = mode_i ^ mode_q;
  assign clr_cnt     = rst_active | mode_change;

  pow2_counter #(.WIDTH(W)) u_cnt (
    .clk_i (clk_i),
    .clr_i (clr_cnt),
    .cnt_o (count)
  );

  pow2_tap_mux #(.WIDTH(W)) u_tap (
    .cnt_i (count),
    .sel_i (tap_sel_i),
    .tap_o (tap_bit)
  );

  pow2_oneshot u_shot (
    .clk_i     (clk_i),
    .clr_i     (clr_cnt),
    .tap_i     (tap_bit),
    .latched_o (latched)
  );

  assign timer_o = out_level(rst_active, pol_i, tmode_e'(mode_i), tap_bit, latched);

  // R1: while cleared the output shows the polarity level
  always_comb begin
    if (rst_active) p_reset_level_r1: assert (timer_o == pol_i);
  end

  // R6: a mode change leaves counter and latch cleared
  always_comb begin
    if (mode_change_q) p_mode_clear_r6: assert (count == '0 && !latched);
  end

  // R2: a held clear keeps the counter at zero on the following edge
  p_hold_r2: assert property (@(posedge clk_i) disable iff (mode_change)
    $past(rst_active) |-> count == '0);
endmodule

// File: tb/pow2_timer_bench.sv
module pow2_timer_bench;
  logic       clk = 1'b0;
  logic       mreset = 1'b1;
  logic       por_req = 1'b0;
  logic       por_dis = 1'b1;
  logic [1:0] tap_sel = 2'b10;
  logic       mode = 1'b1;
  logic       pol = 1'b0;
  logic       tout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pow2_timer u_pow2_timer (
    .clk_i     (clk),
    .mreset_i  (mreset),
    .por_req_i (por_req),
    .por_dis_i (por_dis),
    .tap_sel_i (tap_sel),
    .mode_i    (mode),
    .pol_i     (pol),
    .timer_o   (tout)
  );

  function automatic int half_of(input logic [1:0] s);
    int k;
    k = (s == 2'b00) ? 13 : (s == 2'b01) ? 10 : (s == 2'b10) ? 8 : 16;
    return 1 << (k - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Count edges until the output differs from ref_v.
  task automatic wait_change(input logic ref_v, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (tout !== ref_v) return;
    end
    n = -1;
  endtask

  // Apply the master clear with the given setup, then release it.
  task automatic restart(input logic [1:0] s, input logic m, input logic p);
    @(negedge clk);
    mreset = 1'b1; tap_sel = s; mode = m; pol = p;
    edges(4);
    mreset = 1'b0;
  endtask

  task automatic t_reset_level();
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      mreset = 1'b1; pol = p[0]; mode = 1'b1; tap_sel = 2'b10;
      edges(4);
      check(tout == p[0], "R1 reset level", tout, p);
      edges(300);
      check(tout == p[0], "R2 no counting in reset", tout, p);
    end
  endtask

  task automatic t_tap_map();
    int n;
    for (int s = 0; s < 4; s++) begin
      restart(s[1:0], 1'b1, 1'b0);
      wait_change(1'b0, 40000, n);
      check(n == 2 + half_of(s[1:0]), "R3 tap map", n, 2 + half_of(s[1:0]));
    end
  endtask

  task automatic t_recycle();
    int n;
    restart(2'b10, 1'b1, 1'b1);
    wait_change(1'b1, 1000, n);
    check(n == 130, "R4 first edge inverted", n, 130);
    check(tout == 1'b0, "R4 inverted level", tout, 0);
    wait_change(1'b0, 1000, n);
    check(n == 128, "R4 half period stage 8", n, 128);
    restart(2'b01, 1'b1, 1'b0);
    wait_change(1'b0, 2000, n);
    wait_change(1'b1, 2000, n);
    check(n == 512, "R4 half period stage 10", n, 512);
    wait_change(1'b0, 2000, n);
    check(n == 512, "R4 second half stage 10", n, 512);
  endtask

  task automatic t_oneshot_and_mode();
    int n;
    restart(2'b10, 1'b0, 1'b1);
    wait_change(1'b1, 1000, n);
    check(n == 130, "R5 one-shot fires", n, 130);
    wait_change(1'b0, 600, n);
    check(n == -1, "R5 one-shot holds", n, -1);
    // flip to recycle: clear on the next edge
    mode = 1'b1;
    wait_change(1'b0, 10, n);
    check(n == 1, "R6 mode flip clears output", n, 1);
    wait_change(1'b1, 1000, n);
    check(n == 128, "R6 restart after flip", n, 128);
    // back to single cycle while the tap is high
    mode = 1'b0;
    wait_change(1'b0, 10, n);
    check(n == 1, "R6 latch cleared on flip back", n, 1);
    wait_change(1'b1, 1000, n);
    check(n == 128, "R6 one-shot re-arms", n, 128);
    wait_change(1'b0, 600, n);
    check(n == -1, "R5 holds after re-arm", n, -1);
  endtask

  task automatic t_por();
    int n;
    restart(2'b10, 1'b1, 1'b1);
    por_dis = 1'b0;
    edges(152);
    check(tout == 1'b0, "R7 running before request", tout, 0);
    por_req = 1'b1;
    edges(2);
    check(tout == 1'b1, "R7 por clears output", tout, 1);
    por_req = 1'b0;
    wait_change(1'b1, 1000, n);
    check(n == 130, "R7 count restarts", n, 130);
    // masked request
    restart(2'b10, 1'b1, 1'b1);
    por_dis = 1'b1;
    edges(152);
    por_req = 1'b1;
    edges(3);
    check(tout == 1'b0, "R8 masked request ignored", tout, 0);
    wait_change(1'b0, 1000, n);
    check(n == 103, "R8 count undisturbed", n, 103);
    por_req = 1'b0;
  endtask

  task automatic t_sel_change();
    int n;
    restart(2'b01, 1'b1, 1'b0);
    edges(202);
    check(tout == 1'b0, "R9 stage 10 low at 200", tout, 0);
    tap_sel = 2'b10;
    #1;
    check(tout == 1'b1, "R9 select takes effect at once", tout, 1);
    wait_change(1'b1, 1000, n);
    check(n == 56, "R9 counter not cleared", n, 56);
  endtask

  initial begin
    t_reset_level();
    t_tap_map();
    t_recycle();
    t_oneshot_and_mode();
    t_por();
    t_sel_change();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule